// File: doc/BRIEF.md
# Schedule-Packet Dispatch Controller

This block sits between a host processor and a set of vector compute resources and turns a stream of microcode schedule packets into timed start commands. The host pushes fixed-width packets into one input queue. A router reads them in order and steers each one into a small queue owned by the resource it addresses. It also collects the set of resources named by the packets of the current schedule event. When the packet that closes the event has been steered, the router writes an event word into an event queue. The word holds the event's start time and the resource mask.

A global step controller keeps a scheduled-cycle counter. It holds the oldest event until the counter has reached the event's start time. It then starts every resource in the mask in the same cycle, but only when all of them are idle and each has its packet waiting. If any of them is still busy, the controller raises a stall and freezes the scheduled counter. A free-running elapsed counter keeps advancing, so the difference between the two counters is the dispatch overhead. Each resource has its own small sequencer: it loads its packet on start, shows its operation and configuration, and stays busy until the resource reports completion.

Top module: `sched_dispatch`

## Requirements
- R1: A packet is 40 bits: start time in [39:24], operation type in [23:21], resource index in [20:17], configuration in [16:1], and the event-closing flag in bit [0]. The low log2(NUM_RES) bits of the index select the resource.
- R2: A packet addressed to resource i makes res_start[i] pulse for one cycle with no other resource started. At that pulse res_op[3*i +: 3] and res_cfg[16*i +: 16] carry the packet's type and configuration, and res_busy[i] is 1.
- R3: Packets of one event start together, in the same cycle. Packets without the closing flag start nothing until the closing packet arrives.
- R4: An event fires in the cycle its start time equals the scheduled counter, so the start pulse is seen with sched_cycles equal to start time plus one. An event whose start time is already past fires as soon as its resources are ready.
- R5: While a due event names a busy resource, stall is 1, no resource starts and sched_cycles holds its value.
- R6: elapsed_cycles advances every cycle after reset. Over any window, elapsed growth minus scheduled growth equals the number of stalled cycles.
- R7: When queues are full, pkt_ready goes low. No accepted packet is dropped, and a resource receives its packets in the order they were sent.
- R8: Synchronous active-low reset empties all queues, clears both counters and the partial event mask, and returns every sequencer to idle: pkt_ready=1, res_start=0, res_busy=0, stall=0.
- R9: A resource stays busy from its start pulse until res_done for it. res_done on an idle resource has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Host offers a packet |
| pkt_data | input | 40 | Packet, layout per R1 |
| pkt_ready | output | 1 | Input queue can take a packet |
| res_done | input | NUM_RES | Per-resource completion pulse |
| res_start | output | NUM_RES | Per-resource start pulse |
| res_busy | output | NUM_RES | Per-resource busy flag |
| res_op | output | 3*NUM_RES | Operation type per resource |
| res_cfg | output | 16*NUM_RES | Configuration per resource |
| stall | output | 1 | A due event waits for a busy resource |
| sched_cycles | output | 16 | Scheduled global cycle counter |
| elapsed_cycles | output | ELAPSED_W | Free-running cycle counter |

## Verification
A table of single-packet events, each for a different resource, type and configuration, shows that steering and field extraction are right and that no other resource starts by accident. A two-packet event tells simultaneous release apart from one release per packet. A future start time tells exact time matching apart from early firing. An event that names a busy resource separates stalling from partial starts and checks the overhead arithmetic. A burst of far-future packets to one resource tests back-pressure, loss and ordering, and a reset in the middle of an event shows that no stale work remains.

// File: rtl/sd_pkg.sv
// Shared field widths and packet types for the schedule dispatch block.
package sd_pkg;
    localparam int TIME_W = 16;
    localparam int TYPE_W = 3;
    localparam int IDX_W  = 4;
    localparam int CFG_W  = 16;

    // Host packet, most significant field first.
    typedef struct packed {
        logic [TIME_W-1:0] start;
        logic [TYPE_W-1:0] rtype;
        logic [IDX_W-1:0]  ridx;
        logic [CFG_W-1:0]  cfg;
        logic              last;
    } pkt_t;

    localparam int PKT_W = $bits(pkt_t);

    // Work item stored in a resource queue.
    typedef struct packed {
        logic [TYPE_W-1:0] rtype;
        logic [CFG_W-1:0]  cfg;
    } work_t;

    localparam int WORK_W = $bits(work_t);
endpackage

// File: rtl/sd_fifo.sv
// Synchronous FIFO with a registered occupancy count.
// Assumes: a push when full and a pop when empty are ignored; read data is the head entry.
module sd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Store the incoming entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/sd_router.sv
// Steers the head packet to its resource queue and emits one event word per closing packet.
// Assumes: NUM_RES is a power of two of at least 2; a packet moves only when its
// resource queue has room and, if it closes an event, the event queue has room too.
module sd_router import sd_pkg::*; #(
    parameter int NUM_RES = 4,
    localparam int SEL_W  = $clog2(NUM_RES),
    localparam int EVT_W  = TIME_W + NUM_RES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pkt_t               head,
    input  logic               head_valid,
    input  logic [NUM_RES-1:0] res_full,
    input  logic               evt_full,
    output logic               pop,
    output logic [NUM_RES-1:0] res_push,
    output work_t              work,
    output logic               evt_push,
    output logic [EVT_W-1:0]   evt_word
);
    logic [SEL_W-1:0]   sel;
    logic [NUM_RES-1:0] hit, acc;
    logic               go;

    assign sel        = head.ridx[SEL_W-1:0];
    assign hit        = NUM_RES'(1) << sel;
    assign go         = head_valid && !res_full[sel] && !(head.last && evt_full);
    assign pop        = go;
    assign res_push   = go ? hit : '0;
    assign evt_push   = go && head.last;
    assign evt_word   = {head.start, acc | hit};
    assign work.rtype = head.rtype;
    assign work.cfg   = head.cfg;

    // Collect the resource mask of the event being assembled.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (go) acc <= head.last ? '0 : (acc | hit);
    end
endmodule

// File: rtl/sd_glob_ctrl.sv
// Global step control: releases the oldest event once its start time is reached and
// all of its resources are ready, otherwise stalls the scheduled counter.
// Assumes: start times are compared unsigned against the scheduled counter.
module sd_glob_ctrl import sd_pkg::*; #(
    parameter int NUM_RES   = 4,
    parameter int ELAPSED_W = 32,
    localparam int EVT_W    = TIME_W + NUM_RES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [EVT_W-1:0]     evt_word,
    input  logic [NUM_RES-1:0]   res_ready,
    output logic [NUM_RES-1:0]   start_vec,
    output logic                 evt_pop,
    output logic                 stall,
    output logic [TIME_W-1:0]    sched_cnt,
    output logic [ELAPSED_W-1:0] elapsed_cnt
);
    logic [TIME_W-1:0]  ev_time;
    logic [NUM_RES-1:0] ev_mask;
    logic               due, all_ok, fire;

    assign ev_time   = evt_word[EVT_W-1 -: TIME_W];
    assign ev_mask   = evt_word[NUM_RES-1:0];
    assign due       = evt_valid && (sched_cnt >= ev_time);
    assign all_ok    = ((ev_mask & ~res_ready) == '0);
    assign fire      = due && all_ok;
    assign stall     = due && !all_ok;
    assign evt_pop   = fire;
    assign start_vec = fire ? ev_mask : '0;

    // Scheduled counter holds on stall; elapsed counter always runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_cnt   <= '0;
            elapsed_cnt <= '0;
        end else begin
            if (!stall) sched_cnt <= sched_cnt + 1'b1;
            elapsed_cnt <= elapsed_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sd_res_seq.sv
// Per-resource sequencer: loads its queued work on start, pulses start outward,
// and stays busy until the resource reports done.
// Assumes: start is only given while ready is high.
module sd_res_seq import sd_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              q_valid,
    input  work_t             q_data,
    input  logic              done,
    output logic              q_pop,
    output logic              ready,
    output logic              busy,
    output logic              start_pulse,
    output logic [TYPE_W-1:0] op,
    output logic [CFG_W-1:0]  cfg
);
    typedef enum logic {S_IDLE, S_BUSY} seq_st_t;
    seq_st_t st;

    assign ready = (st == S_IDLE) && q_valid;
    assign busy  = (st == S_BUSY);
    assign q_pop = start;

    // Sequencer state, latched work item and outward start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            start_pulse <= 1'b0;
            op          <= '0;
            cfg         <= '0;
        end else begin
            start_pulse <= start;
            if (start) begin
                st  <= S_BUSY;
                op  <= q_data.rtype;
                cfg <= q_data.cfg;
            end else if (st == S_BUSY && done) begin
                st <= S_IDLE;
            end
        end
    end
endmodule

// File: rtl/sched_dispatch.sv
// Top of the schedule dispatch controller: input queue, router, per-resource queues
// and sequencers, event queue and global step control.
// Assumes: NUM_RES is a power of two between 2 and 16.
module sched_dispatch import sd_pkg::*; #(
    parameter int NUM_RES   = 4,
    parameter int IN_DEPTH  = 4,
    parameter int RES_DEPTH = 2,
    parameter int EVT_DEPTH = 4,
    parameter int ELAPSED_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pkt_valid,
    input  logic [PKT_W-1:0]            pkt_data,
    output logic                        pkt_ready,
    input  logic [NUM_RES-1:0]          res_done,
    output logic [NUM_RES-1:0]          res_start,
    output logic [NUM_RES-1:0]          res_busy,
    output logic [NUM_RES*TYPE_W-1:0]   res_op,
    output logic [NUM_RES*CFG_W-1:0]    res_cfg,
    output logic                        stall,
    output logic [TIME_W-1:0]           sched_cycles,
    output logic [ELAPSED_W-1:0]        elapsed_cycles
);
    localparam int EVT_W = TIME_W + NUM_RES;

    logic [PKT_W-1:0]   in_rdata;
    logic               in_full, in_empty, in_pop;
    logic [NUM_RES-1:0] rq_push, rq_full, rq_empty, rq_pop, rdy, start_vec;
    work_t              work;
    logic               evt_push, evt_full, evt_empty, evt_pop;
    logic [EVT_W-1:0]   evt_wword, evt_rword;

    assign pkt_ready = !in_full;

    sd_fifo #(.W(PKT_W), .DEPTH(IN_DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n), .push(pkt_valid), .wdata(pkt_data),
        .pop(in_pop), .rdata(in_rdata), .full(in_full), .empty(in_empty)
    );

    sd_router #(.NUM_RES(NUM_RES)) u_rt (
        .clk(clk), .rst_n(rst_n), .head(pkt_t'(in_rdata)), .head_valid(!in_empty),
        .res_full(rq_full), .evt_full(evt_full), .pop(in_pop), .res_push(rq_push),
        .work(work), .evt_push(evt_push), .evt_word(evt_wword)
    );

    sd_fifo #(.W(EVT_W), .DEPTH(EVT_DEPTH)) u_evt (
        .clk(clk), .rst_n(rst_n), .push(evt_push), .wdata(evt_wword),
        .pop(evt_pop), .rdata(evt_rword), .full(evt_full), .empty(evt_empty)
    );

    for (genvar i = 0; i < NUM_RES; i++) begin : g_res
        logic [WORK_W-1:0] q_rdata;

        sd_fifo #(.W(WORK_W), .DEPTH(RES_DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .push(rq_push[i]), .wdata(work),
            .pop(rq_pop[i]), .rdata(q_rdata), .full(rq_full[i]), .empty(rq_empty[i])
        );

        sd_res_seq u_seq (
            .clk(clk), .rst_n(rst_n), .start(start_vec[i]), .q_valid(!rq_empty[i]),
            .q_data(work_t'(q_rdata)), .done(res_done[i]), .q_pop(rq_pop[i]),
            .ready(rdy[i]), .busy(res_busy[i]), .start_pulse(res_start[i]),
            .op(res_op[i*TYPE_W +: TYPE_W]), .cfg(res_cfg[i*CFG_W +: CFG_W])
        );
    end

    sd_glob_ctrl #(.NUM_RES(NUM_RES), .ELAPSED_W(ELAPSED_W)) u_gc (
        .clk(clk), .rst_n(rst_n), .evt_valid(!evt_empty), .evt_word(evt_rword),
        .res_ready(rdy), .start_vec(start_vec), .evt_pop(evt_pop), .stall(stall),
        .sched_cnt(sched_cycles), .elapsed_cnt(elapsed_cycles)
    );
endmodule

// File: rtl/sd_dispatch_chk.sv
// Checker for the dispatch controller, bound to the top module.
module sd_dispatch_chk #(
    parameter int NUM_RES   = 4,
    parameter int ELAPSED_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RES-1:0]   res_start,
    input logic [NUM_RES-1:0]   res_busy,
    input logic                 stall,
    input logic [15:0]          sched_cycles,
    input logic [ELAPSED_W-1:0] elapsed_cycles
);
    // R5: a stalled cycle leaves the scheduled counter unchanged
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> sched_cycles == $past(sched_cycles));

    // R5: a stalled cycle starts no resource
    p_stall_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> res_start == '0);

    // R6: without stall the scheduled counter steps by one
    p_sched_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> sched_cycles == $past(sched_cycles) + 16'd1);

    // R6: elapsed counter steps every cycle
    p_elapsed_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> elapsed_cycles == $past(elapsed_cycles) + 1'b1);

    for (genvar i = 0; i < NUM_RES; i++) begin : g_chk
        // R9: a resource only becomes busy together with its start pulse
        p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(res_busy[i]) |-> res_start[i]);
    end
endmodule

bind sched_dispatch sd_dispatch_chk #(.NUM_RES(NUM_RES), .ELAPSED_W(ELAPSED_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_start(res_start), .res_busy(res_busy),
    .stall(stall), .sched_cycles(sched_cycles), .elapsed_cycles(elapsed_cycles)
);

// File: tb/sched_dispatch_test.sv
`timescale 1ns/1ps
module sched_dispatch_test;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_valid = 1'b0;
    logic [39:0]   pkt_data = '0;
    logic          pkt_ready;
    logic [NR-1:0] res_done = '0;
    logic [NR-1:0] res_start, res_busy;
    logic [NR*3-1:0]  res_op;
    logic [NR*16-1:0] res_cfg;
    logic          stall;
    logic [15:0]   sched_cycles;
    logic [31:0]   elapsed_cycles;

    int  n_chk = 0;
    int  n_bad = 0;
    int  stall_edges = 0;
    bit  finished = 1'b0;

    sched_dispatch uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .res_done(res_done), .res_start(res_start),
        .res_busy(res_busy), .res_op(res_op), .res_cfg(res_cfg), .stall(stall),
        .sched_cycles(sched_cycles), .elapsed_cycles(elapsed_cycles)
    );

    always #4 clk = ~clk;

    // Count stalled edges independently of the design's counters.
    always @(posedge clk) if (rst_n && stall) stall_edges <= stall_edges + 1;

    // Table: {resource index, op type, config}
    localparam logic [22:0] VEC [6] = '{
        {4'd0, 3'd1, 16'h1234},
        {4'd1, 3'd5, 16'hA5A5},
        {4'd2, 3'd7, 16'h0F0F},
        {4'd3, 3'd2, 16'hFFFF},
        {4'd6, 3'd3, 16'h4321},
        {4'd1, 3'd0, 16'h0001}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one packet from a falling edge until accepted; returns at a falling edge.
    task automatic send(input logic [15:0] st, input logic [2:0] op, input logic [3:0] idx,
                        input logic [15:0] cfg, input logic last);
        pkt_data  = {st, op, idx, cfg, last};
        pkt_valid = 1'b1;
        while (!pkt_ready) @(negedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic wait_start(input int lim, output logic [NR-1:0] seen);
        seen = '0;
        for (int c = 0; c < lim; c++) begin
            @(negedge clk);
            if (res_start != '0) begin
                seen = res_start;
                return;
            end
        end
    endtask

    task automatic pulse_done(input logic [NR-1:0] m);
        res_done = m;
        @(negedge clk);
        res_done = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NR-1:0] seen;
        logic [15:0]   s0, s1, sa, sb, tgt;
        logic [31:0]   e0, e1;
        int            k0, k1, acc;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(pkt_ready == 1'b1, "R8 ready", pkt_ready, 1);
        chk(res_start == '0 && res_busy == '0, "R8 idle", {res_start, res_busy}, 0);
        chk(stall == 1'b0, "R8 stall", stall, 0);
        chk(sched_cycles == 0 && elapsed_cycles == 0, "R8 counters", elapsed_cycles, 0);
        rst_n = 1'b1;

        // R1 R2: table of single-packet events with past start times
        for (int v = 0; v < 6; v++) begin
            int ri;
            ri = int'(VEC[v][22:19]) % NR;
            send(16'd0, VEC[v][18:16], VEC[v][22:19], VEC[v][15:0], 1'b1);
            wait_start(20, seen);
            chk(seen == NR'(1 << ri), "R2 target", seen, 1 << ri);
            chk(res_cfg[ri*16 +: 16] == VEC[v][15:0], "R1 cfg field", res_cfg[ri*16 +: 16], VEC[v][15:0]);
            chk(res_op[ri*3 +: 3] == VEC[v][18:16], "R1 type field", res_op[ri*3 +: 3], VEC[v][18:16]);
            chk(res_busy[ri] == 1'b1, "R9 busy", res_busy[ri], 1);
            pulse_done(NR'(1 << ri));
            chk(res_busy == '0, "R9 released", res_busy, 0);
        end

        // R9: done on an idle resource is ignored
        pulse_done(4'b0100);
        repeat (2) @(negedge clk);
        chk(res_busy == '0 && res_start == '0, "R9 idle done", {res_busy, res_start}, 0);

        // R3: two packets of one event start together, not before the closing one
        send(16'd0, 3'd4, 4'd0, 16'hAAAA, 1'b0);
        repeat (4) @(negedge clk);
        chk(res_start == '0 && res_busy == '0, "R3 open event", {res_start, res_busy}, 0);
        send(16'd0, 3'd6, 4'd2, 16'hBBBB, 1'b1);
        wait_start(20, seen);
        chk(seen == 4'b0101, "R3 together", seen, 4'b0101);
        chk(res_cfg[0 +: 16] == 16'hAAAA && res_cfg[32 +: 16] == 16'hBBBB, "R3 cfgs",
            {res_cfg[0 +: 16], res_cfg[32 +: 16]}, 32'hAAAABBBB);
        pulse_done(4'b0101);

        // R4: future start time fires exactly on time
        tgt = sched_cycles + 16'd30;
        send(tgt, 3'd1, 4'd3, 16'h3030, 1'b1);
        wait_start(80, seen);
        chk(seen == 4'b1000, "R4 fired", seen, 4'b1000);
        chk(sched_cycles == tgt + 16'd1, "R4 timing", sched_cycles, tgt + 16'd1);
        pulse_done(4'b1000);

        // R5 R6: event naming a busy resource stalls
        send(16'd0, 3'd2, 4'd1, 16'hC0C0, 1'b1);
        wait_start(20, seen);
        chk(seen == 4'b0010, "R5 setup", seen, 4'b0010);
        s0 = sched_cycles; e0 = elapsed_cycles; k0 = stall_edges;
        send(16'd0, 3'd3, 4'd0, 16'hD0D0, 1'b0);
        send(16'd0, 3'd3, 4'd1, 16'hE0E0, 1'b1);
        sa = '0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (c == 3) sa = sched_cycles;
            if (res_start != '0) chk(1'b0, "R5 no start", res_start, 0);
        end
        sb = sched_cycles;
        chk(stall == 1'b1, "R5 stall", stall, 1);
        chk(sa == sb, "R5 counter held", sb, sa);
        chk(res_busy == 4'b0010, "R5 partial start", res_busy, 4'b0010);
        pulse_done(4'b0010);
        wait_start(20, seen);
        chk(seen == 4'b0011, "R5 release", seen, 4'b0011);
        chk(res_cfg[16 +: 16] == 16'hE0E0, "R5 cfg", res_cfg[16 +: 16], 16'hE0E0);
        s1 = sched_cycles; e1 = elapsed_cycles; k1 = stall_edges;
        chk(k1 > k0, "R6 stalls seen", k1 - k0, 1);
        chk(int'(e1 - e0) - int'(16'(s1 - s0)) == k1 - k0, "R6 overhead",
            int'(e1 - e0) - int'(16'(s1 - s0)), k1 - k0);
        pulse_done(4'b0011);

        // R7: back-pressure with far start time, then in-order delivery
        tgt = sched_cycles + 16'd80;
        acc = 0;
        for (int c = 0; c < 20; c++) begin
            pkt_data  = {tgt, 3'd5, 4'd3, 16'hB000 + 16'(acc), 1'b1};
            pkt_valid = 1'b1;
            if (!pkt_ready && acc > 0) break;
            if (pkt_ready) acc++;
            @(negedge clk);
        end
        pkt_valid = 1'b0;
        chk(acc == 6, "R7 accepted", acc, 6);
        repeat (4) @(negedge clk);
        chk(pkt_ready == 1'b0, "R7 ready low", pkt_ready, 0);
        for (int k = 0; k < 6; k++) begin
            wait_start(150, seen);
            chk(seen == 4'b1000, "R7 delivered", seen, 4'b1000);
            chk(res_cfg[48 +: 16] == 16'hB000 + 16'(k), "R7 order", res_cfg[48 +: 16], 16'hB000 + 16'(k));
            pulse_done(4'b1000);
        end

        // R8: reset with work in flight
        send(sched_cycles + 16'd40, 3'd1, 4'd0, 16'hDEAD, 1'b1);
        send(16'd0, 3'd1, 4'd1, 16'hBEEF, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sched_cycles == 0 && elapsed_cycles == 0, "R8 counters cleared", sched_cycles, 0);
        chk(pkt_ready == 1'b1 && res_busy == '0, "R8 cleared", {pkt_ready, res_busy}, 16);
        rst_n = 1'b1;
        send(16'd0, 3'd2, 4'd2, 16'h7777, 1'b1);
        wait_start(20, seen);
        chk(seen == 4'b0100, "R8 no stale mask", seen, 4'b0100);
        chk(res_cfg[32 +: 16] == 16'h7777, "R8 fresh cfg", res_cfg[32 +: 16], 16'h7777);
        pulse_done(4'b0100);
        wait_start(60, seen);
        chk(seen == '0, "R8 stale event gone", seen, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule